// File: doc/BRIEF.md
# USART Host Register Port

This block is the processor-facing side of a serial transmitter/receiver. An 8-bit host talks to it through four control lines: an active-low select, a command/data line, an active-low read strobe and an active-low write strobe. Each access reaches one of three places. The data path carries a byte to the transmitter or returns the byte the receiver has assembled. A read on the command side returns the status byte. A write on the command side goes to the control register.

A single control location serves two register types. After reset, the first control write is stored as the mode word, which sets the frame format and the clock division. Every later control write is a command word, which enables the engines, drives the modem lines, forces a break and clears error flags. This continues until a command sets the internal-reset bit. That command clears the command state and makes the next control write a mode word again.

The bus is not tri-stated inside the block. An output-enable signal marks the cycles in which the block drives the data bus. The serial engines sit outside the block. They receive the mode and command fields, the transmit byte and the single-cycle strobes, and they return their ready and error flags and the received byte.

Top module: `usart_host_port`

## Requirements
- R1: `dout_oe` is 1 exactly when `cs_n`=0, `rd_n`=0 and `wr_n`=1. In every other combination it is 0 and `dout` is 8'h00.
- R2: While `dout_oe` is 1, `dout` carries the status byte when `cd`=1 and `rx_data` when `cd`=0.
- R3: The status byte has the following bits: bit 7 is 1 when `dsr_n` was low at the previous clock edge, bit 6 (sync detect) is always 0, bit 5 is `framing_err`, bit 4 is `overrun_err`, bit 3 is `parity_err`, bit 2 is `tx_empty`, bit 1 is `rx_ready` and bit 0 is `tx_ready`.
- R4: After reset the mode outputs are 0 and the first control write (`cd`=1) is stored as the mode word. Its fields are: `stop_sel`=D7:6, `parity_en`=D4, `parity_odd`=D5&D4, `len_code`=D3:2 and `clk_div_sel`=D1:0.
- R5: Once a mode word is stored, later control writes leave the mode outputs unchanged until an internal reset.
- R6: A command word sets `hunt`=D7, `rts_n`=~D5, `send_break`=D3, `rx_en`=D2, `dtr_n`=~D1 and `tx_en`=D0. After reset all of these command outputs are inactive (`dtr_n`=`rts_n`=1).
- R7: A command word with D6=1 clears all command outputs, and the next control write is taken as a mode word.
- R8: A command word with D4=1 or D6=1 gives an `err_clr` pulse that lasts exactly one clock, in the cycle after the write edge. The D4 bit is never held as a level.
- R9: A data write (`cd`=0) stores the byte on `tx_data` and gives a one-clock `tx_load` pulse.
- R10: A data read (`cd`=0) gives a one-clock `rx_take` pulse in the cycle after the read strobe starts.
- R11: A strobe held low for several clocks causes only one access. When both strobes are low at the same time, no read or write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| cd | input | 1 | 1 = status/control, 0 = data |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| dout_oe | output | 1 | Block drives the data bus |
| rx_data | input | 8 | Byte from the receiver |
| rx_take | output | 1 | Receiver byte consumed pulse |
| tx_data | output | 8 | Byte for the transmitter |
| tx_load | output | 1 | Transmit byte written pulse |
| tx_ready | input | 1 | Transmit buffer empty flag |
| tx_empty | input | 1 | Transmitter idle flag |
| rx_ready | input | 1 | Received byte available flag |
| parity_err | input | 1 | Parity error flag |
| overrun_err | input | 1 | Overrun error flag |
| framing_err | input | 1 | Framing error flag |
| err_clr | output | 1 | Clear error flags pulse |
| stop_sel | output | 2 | Stop bit selection |
| parity_en | output | 1 | Parity enabled |
| parity_odd | output | 1 | Odd parity selected |
| len_code | output | 2 | Character length code (5 + code bits) |
| clk_div_sel | output | 2 | Clock division selection |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| send_break | output | 1 | Force the line low |
| hunt | output | 1 | Hunt request |
| dtr_n | output | 1 | Active-low terminal ready |
| rts_n | output | 1 | Active-low request to send |
| dsr_n | input | 1 | Active-low data set ready |

## Verification
Two actions can fall on the same write edge. An internal reset and an error clear can be requested by one command word, and an internal reset and the choice of register type both act on one control write. The bench writes 8'h50 and checks that a single `err_clr` pulse appears, that the command outputs are zero and that the next control write lands in the mode fields. The bench also lowers both strobes in the same cycle with a data address and checks that the bus is not driven, that there is no `tx_load` or `rx_take` pulse and that `tx_data` keeps its value.

// File: rtl/usart_host_port.sv
module usart_host_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       cd,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_oe,
  input  logic [7:0] rx_data,
  output logic       rx_take,
  output logic [7:0] tx_data,
  output logic       tx_load,
  input  logic       tx_ready,
  input  logic       tx_empty,
  input  logic       rx_ready,
  input  logic       parity_err,
  input  logic       overrun_err,
  input  logic       framing_err,
  output logic       err_clr,
  output logic [1:0] stop_sel,
  output logic       parity_en,
  output logic       parity_odd,
  output logic [1:0] len_code,
  output logic [1:0] clk_div_sel,
  output logic       tx_en,
  output logic       rx_en,
  output logic       send_break,
  output logic       hunt,
  output logic       dtr_n,
  output logic       rts_n,
  input  logic       dsr_n
);

  logic       rd_q, wr_q, dsr_q, expect_mode;
  logic [7:0] mode_q;
  logic       c_hunt, c_rts, c_brk, c_rxe, c_dtr, c_txe;
  logic       wr_go, rd_go, ctl_wr, dat_wr, dat_rd;
  logic [7:0] status;

  // one access per strobe assertion, none if both strobes are low
  assign wr_go  = ~cs_n & ~wr_n & rd_n & wr_q;
  assign rd_go  = ~cs_n & ~rd_n & wr_n & rd_q;
  assign ctl_wr = wr_go & cd;
  assign dat_wr = wr_go & ~cd;
  assign dat_rd = rd_go & ~cd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= 1'b1;
      wr_q <= 1'b1;
      dsr_q <= 1'b0;
    end else begin
      rd_q <= rd_n;
      wr_q <= wr_n;
      dsr_q <= ~dsr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expect_mode <= 1'b1;
      mode_q <= 8'h00;
      {c_hunt, c_rts, c_brk, c_rxe, c_dtr, c_txe} <= 6'b0;
      err_clr <= 1'b0;
    end else begin
      err_clr <= ctl_wr & ~expect_mode & (din[4] | din[6]);
      if (ctl_wr) begin
        if (expect_mode) begin
          mode_q <= din;
          expect_mode <= 1'b0;
        end else if (din[6]) begin
          {c_hunt, c_rts, c_brk, c_rxe, c_dtr, c_txe} <= 6'b0;
          expect_mode <= 1'b1;
        end else begin
          {c_hunt, c_rts, c_brk, c_rxe, c_dtr, c_txe} <=
            {din[7], din[5], din[3], din[2], din[1], din[0]};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_data <= 8'h00;
      tx_load <= 1'b0;
      rx_take <= 1'b0;
    end else begin
      tx_load <= dat_wr;
      rx_take <= dat_rd;
      if (dat_wr) tx_data <= din;
    end
  end

  assign stop_sel    = mode_q[7:6];
  assign parity_en   = mode_q[4];
  assign parity_odd  = mode_q[5] & mode_q[4];
  assign len_code    = mode_q[3:2];
  assign clk_div_sel = mode_q[1:0];

  assign hunt       = c_hunt;
  assign send_break = c_brk;
  assign rx_en      = c_rxe;
  assign tx_en      = c_txe;
  assign dtr_n      = ~c_dtr;
  assign rts_n      = ~c_rts;

  assign status  = {dsr_q, 1'b0, framing_err, overrun_err, parity_err,
                    tx_empty, rx_ready, tx_ready};
  assign dout_oe = ~cs_n & ~rd_n & wr_n;
  assign dout    = dout_oe ? (cd ? status : rx_data) : 8'h00;

  AST_NO_DRIVE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dout_oe); // R1
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !expect_mode |=> $stable(mode_q)); // R5
  AST_DTR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !expect_mode && !din[6]) |=> (dtr_n == !$past(din[1]))); // R6
  AST_IR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !expect_mode && din[6]) |=> (expect_mode && !tx_en && !rx_en && dtr_n)); // R7
  AST_ERRCLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !err_clr); // R8
  AST_TXLOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load); // R9
  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |=> !rx_take); // R10

endmodule

// File: tb/tb_usart_host_port.sv
module tb_usart_host_port;
  logic clk = 0, rst_n = 0, cs_n = 1, cd = 0, rd_n = 1, wr_n = 1, dsr_n = 1;
  logic [7:0] din = 0, rx_data = 0;
  logic tx_ready = 0, tx_empty = 0, rx_ready = 0, parity_err = 0, overrun_err = 0, framing_err = 0;
  logic [7:0] dout, tx_data;
  logic dout_oe, rx_take, tx_load, err_clr, parity_en, parity_odd;
  logic [1:0] stop_sel, len_code, clk_div_sel;
  logic tx_en, rx_en, send_break, hunt, dtr_n, rts_n;
  int checks = 0, fails = 0, n_load, n_err, n_take;
  logic [7:0] last_mode;

  always #2.5 clk = ~clk;

  usart_host_port dut (.*);

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cs_n = 1; rd_n = 1; wr_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic c, input logic [7:0] v, input int hold);
    @(negedge clk); cs_n = 0; cd = c; din = v; wr_n = 0;
    n_load = 0; n_err = 0;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk); n_load += int'(tx_load); n_err += int'(err_clr);
    end
    cs_n = 1; wr_n = 1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); n_load += int'(tx_load); n_err += int'(err_clr);
    end
  endtask

  task automatic chk_mode(input logic [7:0] v, input string req);
    chk({stop_sel, parity_en, parity_odd, len_code, clk_div_sel} ==
        {v[7:6], v[4], v[5] & v[4], v[3:2], v[1:0]}, req,
        {stop_sel, parity_en, parity_odd, len_code, clk_div_sel},
        {v[7:6], v[4], v[5] & v[4], v[3:2], v[1:0]});
  endtask

  task automatic chk_cmd(input logic [7:0] c, input string req);
    chk({hunt, rts_n, send_break, rx_en, dtr_n, tx_en} ==
        {c[7], ~c[5], c[3], c[2], ~c[1], c[0]}, req,
        {hunt, rts_n, send_break, rx_en, dtr_n, tx_en},
        {c[7], ~c[5], c[3], c[2], ~c[1], c[0]});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(dout_oe == 0, "R1 reset", dout_oe, 0);
    chk_cmd(8'h00, "R6 reset");
    chk_mode(8'h00, "R4 reset");

    // R1 R2: full decode sweep of the four control lines
    rx_data = 8'h5A; tx_ready = 1; framing_err = 1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      cs_n = i[3]; cd = i[2]; rd_n = i[1]; wr_n = i[0]; din = 8'h00;
      #1;
      chk(dout_oe == (!i[3] && !i[1] && i[0]), "R1 oe", dout_oe, (!i[3] && !i[1] && i[0]));
      chk(dout == ((!i[3] && !i[1] && i[0]) ? (i[2] ? 8'h21 : 8'h5A) : 8'h00), "R2 dout", dout,
          ((!i[3] && !i[1] && i[0]) ? (i[2] ? 8'h21 : 8'h5A) : 8'h00));
    end
    do_reset();

    // R4: first control write is the mode word; R5: later ones do not touch it
    wr(1, 8'hCA, 1);
    chk_mode(8'hCA, "R4 first");
    chk_cmd(8'h00, "R4 no command");
    last_mode = 8'hCA;

    // R6 R8: command sweep without internal reset
    for (int v = 0; v < 256; v++) begin
      if (v[6] == 1'b0) begin
        wr(1, v[7:0], 1);
        chk_cmd(v[7:0], "R6 command");
        chk_mode(last_mode, "R5 mode held");
        chk(n_err == int'(v[4]), "R8 err pulse", n_err, int'(v[4]));
      end
    end

    // R7 R4: every mode value after internal reset
    for (int v = 0; v < 256; v++) begin
      wr(1, 8'h03, 1);
      wr(1, 8'h40, 1);
      chk_cmd(8'h00, "R7 cleared");
      chk(n_err == 1, "R8 err on IR", n_err, 1);
      wr(1, v[7:0], 1);
      chk_mode(v[7:0], "R4 R7 mode");
      chk(n_err == 0, "R8 no err on mode", n_err, 0);
      last_mode = v[7:0];
    end

    // R7 R8: internal reset and error reset in the same word
    wr(1, 8'h25, 1);
    wr(1, 8'h50, 1);
    chk(n_err == 1, "R8 R7 combined", n_err, 1);
    chk_cmd(8'h00, "R7 combined");
    wr(1, 8'h9E, 1);
    chk_mode(8'h9E, "R7 next is mode");

    // R3: status sweep
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      {dsr_n, framing_err, overrun_err, parity_err, tx_empty, rx_ready, tx_ready} = i[6:0];
      cs_n = 0; cd = 1; rd_n = 0;
      @(negedge clk);
      chk(dout == {~i[6], 1'b0, i[5:0]}, "R3 status", dout, {~i[6], 1'b0, i[5:0]});
      cs_n = 1; rd_n = 1;
    end

    // R9 R11: data writes, some held several clocks
    for (int i = 0; i < 16; i++) begin
      wr(0, 8'(i * 37 + 5), 1 + (i % 3));
      chk(tx_data == 8'(i * 37 + 5), "R9 tx_data", tx_data, 8'(i * 37 + 5));
      chk(n_load == 1, "R9 R11 one load", n_load, 1);
    end

    // R10 R11: data read held three clocks
    rx_data = 8'hC3;
    @(negedge clk); cs_n = 0; cd = 0; rd_n = 0; n_take = 0;
    #1 chk(dout == 8'hC3, "R2 rx data", dout, 8'hC3);
    for (int k = 0; k < 3; k++) begin @(negedge clk); n_take += int'(rx_take); end
    cs_n = 1; rd_n = 1;
    for (int k = 0; k < 2; k++) begin @(negedge clk); n_take += int'(rx_take); end
    chk(n_take == 1, "R10 one take", n_take, 1);

    // R11: both strobes low together
    @(negedge clk); cs_n = 0; cd = 0; rd_n = 0; wr_n = 0; din = 8'hEE; n_take = 0; n_load = 0;
    #1 chk(dout_oe == 0, "R11 no drive", dout_oe, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); n_take += int'(rx_take); n_load += int'(tx_load);
    end
    cs_n = 1; rd_n = 1; wr_n = 1;
    chk(n_take == 0 && n_load == 0, "R11 no access", n_take + n_load, 0);
    chk(tx_data == 8'(15 * 37 + 5), "R11 tx_data kept", tx_data, 8'(15 * 37 + 5));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule